// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupts and Input Filtering

This block is a sixteen-line general-purpose input/output controller, controlled through a small memory-mapped register set of 16-bit registers. Software chooses, one bit per line, whether a line drives or listens. For a driving line it chooses push-pull or open-drain behaviour. For a listening line it chooses normal or inverted sense, level or edge interrupt behaviour, and whether a debounce filter sits in front of the line. The filter is meant for switches, relays and other bouncing contacts.

The block drives per-line output-enable and output-value pins for an external pad ring. It takes raw pin levels back in through a two-flop synchronizer and an optional per-line filter. It keeps a sticky or level-following status bit per line and combines the enabled status bits into one interrupt output. Software can change single output bits without a read-modify-write by using write-one-to-set and write-one-to-clear registers.

Each line's debounce filter is a two-state machine. DB_STEADY holds the accepted level. It moves to DB_WAIT when the synchronized input differs from that level. DB_WAIT returns to DB_STEADY in three cases: the input goes back to the accepted level (the glitch is rejected), the count of DEB_TICKS cycles completes (the new level is accepted), or the filter is disabled.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every read/write register reads 0x0000: direction, polarity, drive type, interrupt type, filter enable, output data, status and interrupt enable. pin_oe and pin_out are 0 and irq is 0.
- R2: Register byte offsets are: 0x30 direction, 0x32 polarity, 0x34 drive type, 0x36 interrupt type, 0x38 filter enable, 0x40 input view (read-only, writes ignored), 0x42 output data, 0x44 status, 0x46 interrupt enable, 0x4C clear, 0x4E set. The five configuration registers, output data and interrupt enable read back what was written. Clear and set read 0x0000.
- R3: A direction bit of 1 makes the line an output. With drive type bit 0 (push-pull), pin_oe=1 and pin_out equals the data bit. With drive type bit 1 (open-drain), pin_oe is the inverse of the data bit and pin_out=0. An input line has pin_oe=0 and pin_out=0. Pins follow a register write from the next clock edge.
- R4: Writing to the set register turns on only the output data bits written as 1. Writing to the clear register turns off only the output data bits written as 1. All other bits keep their value.
- R5: The input view register returns the synchronized pin value XOR the polarity bits. With the filter off, a pin change appears after two clock edges and not after one.
- R6: On an input line with its filter bit set, a level held at the pin appears in the input view after DEB_TICKS+3 clock edges and not after DEB_TICKS+2. A pulse shorter than DEB_TICKS cycles never appears.
- R7: A polarity bit of 1 inverts both the input view and the level that counts as asserted for interrupts. With that bit set, a low pin is asserted.
- R8: A level-type line (interrupt type bit 0) has a status bit equal to its asserted level, registered three clock edges after a pin change. Writing 1 to its status bit has no effect.
- R9: An edge-type line (interrupt type bit 1) sets its status bit three edges after an asserting transition. The bit stays set after the line deasserts, and a deasserting transition does not set it. Writing 1 to the bit at offset 0x44 clears it. A new edge in the same cycle as the clear wins.
- R10: irq is the OR of the status bits whose interrupt enable bit is 1. Status bits still set while their enable bit is 0.
- R11: A line configured as an output never raises a level-type status bit, and its pin value still appears in the input view.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, 0 when not selected |
| pin_in | input | 16 | Raw pin levels from the pads |
| pin_oe | output | 16 | Per-line output enable |
| pin_out | output | 16 | Per-line output value |
| irq | output | 1 | Combined interrupt |

## Verification
Results fall due at fixed times. Register writes take effect at the edge that samples them. The input view lags the pins by two edges, or by DEB_TICKS+3 edges when filtered. Status and irq lag the pins by three edges, and a polarity change reaches status one edge after the write. The bench drives and samples on the falling edge. It counts rising edges exactly, and wherever a latency is claimed it checks both the edge before the result is due, where the old value must hold, and the edge where it is due. The glitch and the deasserting-edge cases are held long enough past the latency that a late, wrong change would be seen.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int GP_ADDR_W = 8;

    localparam logic [GP_ADDR_W-1:0] OFS_DIR   = 8'h30;
    localparam logic [GP_ADDR_W-1:0] OFS_POL   = 8'h32;
    localparam logic [GP_ADDR_W-1:0] OFS_DRV   = 8'h34;
    localparam logic [GP_ADDR_W-1:0] OFS_ITYP  = 8'h36;
    localparam logic [GP_ADDR_W-1:0] OFS_FILT  = 8'h38;
    localparam logic [GP_ADDR_W-1:0] OFS_VIEW  = 8'h40;
    localparam logic [GP_ADDR_W-1:0] OFS_DATA  = 8'h42;
    localparam logic [GP_ADDR_W-1:0] OFS_STAT  = 8'h44;
    localparam logic [GP_ADDR_W-1:0] OFS_IEN   = 8'h46;
    localparam logic [GP_ADDR_W-1:0] OFS_CLR   = 8'h4C;
    localparam logic [GP_ADDR_W-1:0] OFS_SET   = 8'h4E;

    typedef enum logic [0:0] {
        DB_STEADY = 1'b0,
        DB_WAIT   = 1'b1
    } db_state_t;

endpackage

// File: rtl/gpio_line_in.sv
module gpio_line_in
    import gpio_pkg::*;
#(
    parameter int DEB_TICKS = 16,
    localparam int CNT_W    = $clog2(DEB_TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic filt_en_i,
    output logic level_o
);

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_TICKS - 1);

    logic             meta_q;
    logic             sync_q;
    logic             held_q;
    logic [CNT_W-1:0] cnt_q;
    db_state_t        st_q;
    db_state_t        st_d;

    // two-flop synchronizer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= DB_STEADY;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DB_STEADY: begin
                if (filt_en_i && (sync_q != held_q)) begin
                    st_d = DB_WAIT;
                end
            end
            DB_WAIT: begin
                if (!filt_en_i || (sync_q == held_q) || (cnt_q == CNT_LAST)) begin
                    st_d = DB_STEADY;
                end
            end
        endcase
    end

    // counter and accepted level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!filt_en_i) begin
            held_q <= sync_q;
            cnt_q  <= '0;
        end else begin
            unique case (st_q)
                DB_STEADY: cnt_q <= '0;
                DB_WAIT: begin
                    if (sync_q == held_q) begin
                        cnt_q <= '0;
                    end else if (cnt_q == CNT_LAST) begin
                        held_q <= sync_q;
                        cnt_q  <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign level_o = filt_en_i ? held_q : sync_q;

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int LINES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] asserted_i,
    input  logic [LINES-1:0] edge_mode_i,
    input  logic [LINES-1:0] enable_i,
    input  logic [LINES-1:0] w1c_i,
    output logic [LINES-1:0] status_o,
    output logic             irq_o
);

    logic [LINES-1:0] prev_q;
    logic [LINES-1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= asserted_i;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_stat
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[g] <= 1'b0;
            end else if (edge_mode_i[g]) begin
                if (asserted_i[g] && !prev_q[g]) begin
                    stat_q[g] <= 1'b1;
                end else if (w1c_i[g]) begin
                    stat_q[g] <= 1'b0;
                end
            end else begin
                stat_q[g] <= asserted_i[g];
            end
        end
    end

    assign status_o = stat_q;
    assign irq_o    = |(stat_q & enable_i);

endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
    import gpio_pkg::*;
#(
    parameter int LINES     = 16,
    parameter int DEB_TICKS = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [GP_ADDR_W-1:0] bus_addr,
    input  logic [LINES-1:0]     bus_wdata,
    output logic [LINES-1:0]     bus_rdata,
    input  logic [LINES-1:0]     pin_in,
    output logic [LINES-1:0]     pin_oe,
    output logic [LINES-1:0]     pin_out,
    output logic                 irq
);

    logic [LINES-1:0] dir_q;
    logic [LINES-1:0] pol_q;
    logic [LINES-1:0] drv_q;
    logic [LINES-1:0] ityp_q;
    logic [LINES-1:0] filt_q;
    logic [LINES-1:0] data_q;
    logic [LINES-1:0] ien_q;

    logic [LINES-1:0] level_vec;
    logic [LINES-1:0] view_vec;
    logic [LINES-1:0] asserted_vec;
    logic [LINES-1:0] w1c_vec;
    logic [LINES-1:0] status_q;
    logic [LINES-1:0] rd_val;
    logic             wr_en;

    assign wr_en = bus_sel && bus_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            pol_q  <= '0;
            drv_q  <= '0;
            ityp_q <= '0;
            filt_q <= '0;
            data_q <= '0;
            ien_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                OFS_DIR:  dir_q  <= bus_wdata;
                OFS_POL:  pol_q  <= bus_wdata;
                OFS_DRV:  drv_q  <= bus_wdata;
                OFS_ITYP: ityp_q <= bus_wdata;
                OFS_FILT: filt_q <= bus_wdata;
                OFS_DATA: data_q <= bus_wdata;
                OFS_IEN:  ien_q  <= bus_wdata;
                OFS_CLR:  data_q <= data_q & ~bus_wdata;
                OFS_SET:  data_q <= data_q | bus_wdata;
                default: ;
            endcase
        end
    end

    assign w1c_vec = (wr_en && (bus_addr == OFS_STAT)) ? bus_wdata : '0;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        gpio_line_in #(
            .DEB_TICKS (DEB_TICKS)
        ) u_in (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_i     (pin_in[g]),
            .filt_en_i (filt_q[g] & ~dir_q[g]),
            .level_o   (level_vec[g])
        );

        assign pin_oe[g]  = dir_q[g] & (drv_q[g] ? ~data_q[g] : 1'b1);
        assign pin_out[g] = dir_q[g] & ~drv_q[g] & data_q[g];
    end

    assign view_vec     = level_vec ^ pol_q;
    assign asserted_vec = view_vec & ~dir_q;

    gpio_irq_unit #(
        .LINES (LINES)
    ) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .asserted_i  (asserted_vec),
        .edge_mode_i (ityp_q),
        .enable_i    (ien_q),
        .w1c_i       (w1c_vec),
        .status_o    (status_q),
        .irq_o       (irq)
    );

    always_comb begin
        case (bus_addr)
            OFS_DIR:  rd_val = dir_q;
            OFS_POL:  rd_val = pol_q;
            OFS_DRV:  rd_val = drv_q;
            OFS_ITYP: rd_val = ityp_q;
            OFS_FILT: rd_val = filt_q;
            OFS_VIEW: rd_val = view_vec;
            OFS_DATA: rd_val = data_q;
            OFS_STAT: rd_val = status_q;
            OFS_IEN:  rd_val = ien_q;
            default:  rd_val = '0;
        endcase
    end

    assign bus_rdata = bus_sel ? rd_val : '0;

endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk
    import gpio_pkg::*;
#(
    parameter int LINES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [GP_ADDR_W-1:0] bus_addr,
    input logic [LINES-1:0]     bus_wdata,
    input logic [LINES-1:0]     pin_oe,
    input logic [LINES-1:0]     pin_out,
    input logic                 irq,
    input logic [LINES-1:0]     dir_q,
    input logic [LINES-1:0]     drv_q,
    input logic [LINES-1:0]     ityp_q,
    input logic [LINES-1:0]     ien_q,
    input logic [LINES-1:0]     data_q,
    input logic [LINES-1:0]     status_q
);

    logic [LINES-1:0] clr_v;
    logic             wr_set;
    logic             wr_clr;

    assign wr_set = bus_sel && bus_wr && (bus_addr == OFS_SET);
    assign wr_clr = bus_sel && bus_wr && (bus_addr == OFS_CLR);
    assign clr_v  = (bus_sel && bus_wr && (bus_addr == OFS_STAT)) ? bus_wdata : '0;

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & ~dir_q) == '0); // R3

    AST_OD_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & drv_q & data_q) == '0); // R3

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R3

    AST_SET_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> data_q == ($past(data_q) | $past(bus_wdata))); // R4

    AST_CLR_ONLY_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> data_q == ($past(data_q) & ~$past(bus_wdata))); // R4

    AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status_q & ityp_q & ~clr_v) & ityp_q & ~status_q) == '0)); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ien_q == '0) |-> !irq); // R10

    AST_OUTPUT_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(dir_q & ~ityp_q) & ~ityp_q & status_q) == '0)); // R11

endmodule

bind gpio_ctrl gpio_ctrl_chk #(
    .LINES (LINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .irq       (irq),
    .dir_q     (dir_q),
    .drv_q     (drv_q),
    .ityp_q    (ityp_q),
    .ien_q     (ien_q),
    .data_q    (data_q),
    .status_q  (status_q)
);

// File: tb/test_gpio_ctrl.sv
`timescale 1ns/1ps
module test_gpio_ctrl;

    localparam int N   = 16;
    localparam int DEB = 16;

    localparam logic [7:0] A_DIR  = 8'h30;
    localparam logic [7:0] A_POL  = 8'h32;
    localparam logic [7:0] A_DRV  = 8'h34;
    localparam logic [7:0] A_ITYP = 8'h36;
    localparam logic [7:0] A_FILT = 8'h38;
    localparam logic [7:0] A_VIEW = 8'h40;
    localparam logic [7:0] A_DATA = 8'h42;
    localparam logic [7:0] A_STAT = 8'h44;
    localparam logic [7:0] A_IEN  = 8'h46;
    localparam logic [7:0] A_CLR  = 8'h4C;
    localparam logic [7:0] A_SET  = 8'h4E;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_sel = 1'b0;
    logic         bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pin_oe;
    logic [N-1:0] pin_out;
    logic         irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    gpio_ctrl #(.LINES(N), .DEB_TICKS(DEB)) i_gpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [7:0] a, input logic [N-1:0] e);
        logic [N-1:0] v;
        rd(a, v);
        chk(req, $sformatf("reg %h", a), v, e);
    endtask

    task automatic settle();
        pin_in = '0;
        wr(A_DIR, '0); wr(A_POL, '0); wr(A_DRV, '0); wr(A_ITYP, '0);
        wr(A_FILT, '0); wr(A_IEN, '0); wr(A_DATA, '0);
        tick(DEB + 6);
        wr(A_STAT, '1);
    endtask

    task automatic t_reset();
        expect_reg("R1", A_DIR, '0);
        expect_reg("R1", A_POL, '0);
        expect_reg("R1", A_DRV, '0);
        expect_reg("R1", A_ITYP, '0);
        expect_reg("R1", A_FILT, '0);
        expect_reg("R1", A_DATA, '0);
        expect_reg("R1", A_STAT, '0);
        expect_reg("R1", A_IEN, '0);
        chk("R1", "pin_oe", pin_oe, '0);
        chk("R1", "pin_out", pin_out, '0);
        chk("R1", "irq", {15'd0, irq}, '0);
    endtask

    task automatic t_regs();
        wr(A_POL, 16'h1357);  expect_reg("R2", A_POL, 16'h1357);
        wr(A_DRV, 16'h2468);  expect_reg("R2", A_DRV, 16'h2468);
        wr(A_ITYP, 16'h0F0F); expect_reg("R2", A_ITYP, 16'h0F0F);
        wr(A_FILT, 16'hA0A0); expect_reg("R2", A_FILT, 16'hA0A0);
        wr(A_IEN, 16'h8001);  expect_reg("R2", A_IEN, 16'h8001);
        wr(A_DIR, 16'hC3C3);  expect_reg("R2", A_DIR, 16'hC3C3);
        wr(A_DATA, 16'h5AA5); expect_reg("R2", A_DATA, 16'h5AA5);
        wr(A_POL, '0);
        wr(A_VIEW, 16'hFFFF); expect_reg("R2", A_VIEW, 16'h0000);
        expect_reg("R2", A_CLR, '0);
        expect_reg("R2", A_SET, '0);
        settle();
    endtask

    task automatic t_drive();
        logic [N-1:0] d = 16'h0033, dr = 16'h00FF, od = 16'h000F;
        wr(A_DRV, od);
        wr(A_DATA, d);
        chk("R3", "input lines oe", pin_oe, '0);
        chk("R3", "input lines out", pin_out, '0);
        wr(A_DIR, dr);
        chk("R3", "mixed oe", pin_oe, dr & ((od & ~d) | ~od));
        chk("R3", "mixed out", pin_out, dr & ~od & d);
        wr(A_DATA, 16'h00CC);
        chk("R3", "od release", pin_oe, 16'h00F3);
        chk("R3", "pp value", pin_out, 16'h00C0);
        settle();
    endtask

    task automatic t_setclr();
        logic [N-1:0] v;
        wr(A_DIR, 16'hFFFF);
        wr(A_DATA, 16'h0F0F);
        wr(A_SET, 16'h3000);
        rd(A_DATA, v); chk("R4", "after set", v, 16'h3F0F);
        wr(A_CLR, 16'h0101);
        rd(A_DATA, v); chk("R4", "after clear", v, 16'h3E0E);
        chk("R4", "pins follow", pin_out, 16'h3E0E);
        wr(A_SET, 16'h0000);
        rd(A_DATA, v); chk("R4", "set zero", v, 16'h3E0E);
        settle();
    endtask

    task automatic t_input();
        @(negedge clk);
        pin_in = 16'h1234;
        tick(1); expect_reg("R5", A_VIEW, 16'h0000);
        tick(1); expect_reg("R5", A_VIEW, 16'h1234);
        settle();
    endtask

    task automatic t_debounce();
        wr(A_FILT, 16'h0001);
        @(negedge clk);
        pin_in = 16'h0003;
        tick(2);       expect_reg("R5", A_VIEW, 16'h0002);
        tick(DEB);     expect_reg("R6", A_VIEW, 16'h0002);
        tick(1);       expect_reg("R6", A_VIEW, 16'h0003);
        pin_in = 16'h0002;
        tick(DEB / 2);
        pin_in = 16'h0003;
        tick(DEB + 6); expect_reg("R6", A_VIEW, 16'h0003);
        settle();
    endtask

    task automatic t_polarity();
        logic [N-1:0] v;
        wr(A_IEN, 16'h0010);
        wr(A_POL, 16'h00F0);
        expect_reg("R7", A_VIEW, 16'h00F0);
        tick(1);
        rd(A_STAT, v); chk("R7", "inverted level status", v, 16'h00F0);
        chk("R7", "irq", {15'd0, irq}, 16'h0001);
        @(negedge clk);
        pin_in = 16'h0010;
        tick(3);
        rd(A_STAT, v); chk("R7", "high pin deasserted", v, 16'h00E0);
        chk("R7", "irq off", {15'd0, irq}, '0);
        settle();
    endtask

    task automatic t_level();
        logic [N-1:0] v;
        @(negedge clk);
        pin_in = 16'h0020;
        tick(2); rd(A_STAT, v); chk("R8", "not yet", v, '0);
        tick(1); rd(A_STAT, v); chk("R8", "level set", v, 16'h0020);
        wr(A_STAT, 16'h0020);
        rd(A_STAT, v); chk("R8", "w1c ignored", v, 16'h0020);
        pin_in = 16'h0000;
        tick(3); rd(A_STAT, v); chk("R8", "follows low", v, '0);
        settle();
    endtask

    task automatic t_edge();
        logic [N-1:0] v;
        wr(A_ITYP, 16'h0100);
        @(negedge clk);
        pin_in = 16'h0100;
        tick(2); rd(A_STAT, v); chk("R9", "not yet", v, '0);
        tick(1); rd(A_STAT, v); chk("R9", "edge set", v, 16'h0100);
        pin_in = 16'h0000;
        tick(5); rd(A_STAT, v); chk("R9", "sticky", v, 16'h0100);
        wr(A_STAT, 16'h0100);
        rd(A_STAT, v); chk("R9", "w1c", v, '0);
        pin_in = 16'h0100;
        tick(5);
        wr(A_STAT, 16'h0100);
        pin_in = 16'h0000;
        tick(5); rd(A_STAT, v); chk("R9", "falling edge ignored", v, '0);
        settle();
    endtask

    task automatic t_mask();
        logic [N-1:0] v;
        @(negedge clk);
        pin_in = 16'h0004;
        tick(3);
        rd(A_STAT, v); chk("R10", "status while masked", v, 16'h0004);
        chk("R10", "irq masked", {15'd0, irq}, '0);
        wr(A_IEN, 16'h0004);
        chk("R10", "irq enabled", {15'd0, irq}, 16'h0001);
        wr(A_IEN, 16'hFFFB);
        chk("R10", "other enables", {15'd0, irq}, '0);
        settle();
    endtask

    task automatic t_outdir();
        logic [N-1:0] v;
        wr(A_DIR, 16'h0200);
        wr(A_IEN, 16'hFFFF);
        @(negedge clk);
        pin_in = 16'h0200;
        tick(4);
        rd(A_STAT, v); chk("R11", "no status", v, '0);
        chk("R11", "no irq", {15'd0, irq}, '0);
        expect_reg("R11", A_VIEW, 16'h0200);
        settle();
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_regs();
        t_drive();
        t_setclr();
        t_input();
        t_debounce();
        t_polarity();
        t_level();
        t_edge();
        t_mask();
        t_outdir();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule